// File: doc/BRIEF.md
# I2C Bit-Rate Generator

This block turns the system clock into the bit-rate timing for an I2C master. It divides in two stages. The first stage is a power-of-two prescaler whose ratio is set by a 2-bit select code. The second stage is an 8-bit programmable counter. The number of prescaler pulses it counts per half period is the divider value plus three, plus two more when the filter bit is set.

The block drives a square-wave SCL reference with a 50% duty cycle. It also drives a one-cycle tick on every edge of that reference, so the bit engine can shift data or sample the bus on the tick. The enable, select and filter controls arrive packed in a 4-bit mode field, in the layout that the register file in front of this block decodes.

Software picks the divider and select values that best meet a target speed. When enable goes high the block samples the current settings. From then on it takes new settings only at the end of a full SCL period, so a reprogramming never shortens or stretches a half period.

Top module: `i2c_bitrate_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, scl_o and tick_o are 0 after that edge.
- R2: The mode field has the following layout. Bit 0 is enable, bits 2:1 are the prescaler select and bit 3 is the filter bit. While enable is 0, scl_o and tick_o stay 0 and both counters are held at zero. Disabling in mid-period drives scl_o to 0 after the next edge. Re-enabling restarts from a zero phase.
- R3: The prescaler divides the clock by 32, 16, 8 or 4 for select codes 0, 1, 2 and 3.
- R4: Each half period of scl_o lasts P × (div_i + 3 + 2·filter) clock cycles, where P is the prescaler ratio. This gives a full SCL division of P × 2 × (div_i + 3 + 2·filter).
- R5: tick_o is high for exactly one cycle. While enabled, it is high in exactly the cycles in which scl_o has just changed level.
- R6: After enable, the first edge of scl_o is rising. High and low phases have equal length.
- R7: Changes to div_i or to the select and filter bits while running have no effect until the falling edge of scl_o that ends the current full period. The following half periods use the new values.
- R8: The settings present on the first enabled clock edge are used for the first period. The first tick follows that edge by exactly one half period: after P × (div_i + 3 + 2·filter) rising edges, counting that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Bit 0 enable, bits 2:1 prescaler select, bit 3 filter |
| div_i | input | 8 | Second-stage divider value, 0 to 255 |
| tick_o | output | 1 | One-cycle pulse on every SCL level change |
| scl_o | output | 1 | Square-wave SCL reference |

## Verification
The bench drives all eight select and filter combinations, each at several divider values. This separates the prescaler ratio from the second-stage count, and it shows that the filter adds two to the count rather than scaling it. It also sweeps the divider over its low range at one select code, and it tries the largest divider at both the slowest and the fastest prescaler. These catch off-by-one errors and truncation in the count width. Two further sequences test the timing of control changes. One changes the settings just after the start of the first half and again after the first rising edge, which shows that the new values wait for the end of the full period. The other disables the block with the SCL reference high, which shows the forced low level and the restart from a zero phase.

// File: rtl/i2cbrg_pkg.sv
// Package: shared helpers for the I2C bit-rate generator.
// Assumes the prescaler select never exceeds the log2 of the largest ratio.
package i2cbrg_pkg;

    // Shift amount of the prescaler ratio for a given select code (clamped at 0).
    function automatic int pre_shift(input int log_max, input int sel);
        int s;
        s = log_max - sel;
        if (s < 0) s = 0;
        return s;
    endfunction

    // Extra half-period pulses that the filter bit adds.
    localparam int FILT_EXTRA = 2;
    // Fixed part of the half-period count on top of the divider value.
    localparam int BASE_EXTRA = 3;

endpackage

// File: rtl/brg_cfg_shadow.sv
// Module: brg_cfg_shadow
// Keeps a copy of the prescaler select and the half-period terminal count.
// The copy reloads while the generator is idle and at each full-period end.
// While the generator is idle the live inputs go straight through, so the
// first enabled edge already uses the values present on it.
// Assumes load is high whenever running is low.
module brg_cfg_shadow
    import i2cbrg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SEL_W = 2,
    localparam int HALF_W = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              load,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              filt_in,
    input  logic [DIV_W-1:0]  div_in,
    output logic [SEL_W-1:0]  sel_q,
    output logic [HALF_W-1:0] last_q,
    output logic [SEL_W-1:0]  sel_eff,
    output logic [HALF_W-1:0] last_eff
);

    logic [HALF_W-1:0] last_live;

    // Terminal count = div + 3 + 2*filt - 1, precomputed once per load.
    always_comb begin
        last_live = {1'b0, div_in} + HALF_W'(BASE_EXTRA - 1)
                  + (filt_in ? HALF_W'(FILT_EXTRA) : HALF_W'(0));
    end

    // Capture the settings on a load request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            last_q <= HALF_W'(BASE_EXTRA - 1);
        end else if (load) begin
            sel_q  <= sel_in;
            last_q <= last_live;
        end
    end

    // Pick the live settings on the first enabled edge, the stored ones after.
    always_comb begin
        sel_eff  = running ? sel_q  : sel_in;
        last_eff = running ? last_q : last_live;
    end

endmodule

// File: rtl/brg_prescaler.sv
// Module: brg_prescaler
// First stage: a power-of-two divider whose ratio is 2^(LOG_MAX - sel).
// Emits a one-cycle-wide combinational pulse on its last count.
// Assumes the selected ratio is at least 2.
module brg_prescaler
    import i2cbrg_pkg::*;
#(
    parameter int LOG_MAX = 5,
    parameter int SEL_W   = 2,
    localparam int CNT_W  = LOG_MAX,
    localparam int CMP_W  = LOG_MAX + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);

    logic [CNT_W-1:0] cnt;
    logic [CMP_W-1:0] ratio_m1;

    // Last count value for the selected ratio.
    always_comb begin
        ratio_m1 = (CMP_W'(1) << pre_shift(LOG_MAX, int'(sel))) - CMP_W'(1);
        pulse    = en && ({1'b0, cnt} == ratio_m1);
    end

    // Count clock cycles; wrap on the pulse, hold at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (pulse) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/brg_half_stage.sv
// Module: brg_half_stage
// Second stage: counts prescaler pulses up to the terminal count, then toggles
// the SCL reference and raises a one-cycle tick. Flags the end of a full
// period (high-to-low toggle) so the settings can reload there.
// Assumes the terminal count is stable except at a full-period end.
module brg_half_stage #(
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              step,
    input  logic [HALF_W-1:0] last,
    output logic              scl,
    output logic              tick,
    output logic              period_end
);

    logic [HALF_W-1:0] cnt;
    logic              half_done;

    // Detect the last pulse of a half period and of a full period.
    always_comb begin
        half_done  = step && (cnt == last);
        period_end = half_done && scl;
    end

    // Count pulses, toggle the reference, and raise the tick for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            scl  <= 1'b0;
            tick <= 1'b0;
        end else begin
            tick <= half_done;
            if (half_done) begin
                cnt <= '0;
                scl <= ~scl;
            end else if (step) begin
                cnt <= cnt + HALF_W'(1);
            end
        end
    end

endmodule

// File: rtl/i2c_bitrate_gen.sv
// Module: i2c_bitrate_gen (top)
// Two-stage I2C bit-rate generator: a power-of-two prescaler followed by a
// divide-by-(div + 3 + 2*filter) half-period counter that drives a square wave
// and a tick on every edge. Mode layout: [0] enable, [SEL_W:1] select,
// [SEL_W+1] filter. Assumes mode_i and div_i are synchronous to clk.
module i2c_bitrate_gen #(
    parameter int DIV_W   = 8,
    parameter int SEL_W   = 2,
    parameter int LOG_MAX = 5,
    localparam int MODE_W = SEL_W + 2,
    localparam int HALF_W = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              tick_o,
    output logic              scl_o
);

    logic              en;
    logic [SEL_W-1:0]  sel_in;
    logic              filt_in;
    logic              running;
    logic              period_end;
    logic              shadow_load;
    logic              pre_pulse;
    logic [SEL_W-1:0]  cfg_sel;
    logic [HALF_W-1:0] cfg_last;
    logic [SEL_W-1:0]  sel_eff;
    logic [HALF_W-1:0] last_eff;

    // Split the mode field into its controls.
    always_comb begin
        en          = mode_i[0];
        sel_in      = mode_i[SEL_W:1];
        filt_in     = mode_i[SEL_W+1];
        shadow_load = !running || period_end;
    end

    // Remember whether the previous edge was an enabled one.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= en;
    end

    brg_cfg_shadow #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .load     (shadow_load),
        .sel_in   (sel_in),
        .filt_in  (filt_in),
        .div_in   (div_i),
        .sel_q    (cfg_sel),
        .last_q   (cfg_last),
        .sel_eff  (sel_eff),
        .last_eff (last_eff)
    );

    brg_prescaler #(.LOG_MAX(LOG_MAX), .SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .sel   (sel_eff),
        .pulse (pre_pulse)
    );

    brg_half_stage #(.HALF_W(HALF_W)) u_half (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .step       (pre_pulse),
        .last       (last_eff),
        .scl        (scl_o),
        .tick       (tick_o),
        .period_end (period_end)
    );

endmodule

// File: rtl/i2c_bitrate_gen_chk.sv
// Module: i2c_bitrate_gen_chk
// Checker bound to the generator top: output pulse shape, idle behaviour and
// stability of the stored settings between full-period ends.
module i2c_bitrate_gen_chk #(
    parameter int SEL_W  = 2,
    parameter int HALF_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              tick,
    input logic              scl,
    input logic              running,
    input logic              period_end,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic [HALF_W-1:0] cfg_last
);

    // R2: disabled edge leaves both outputs low
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!tick && !scl));

    // R5: a tick never lasts two cycles
    p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5: every tick marks an SCL level change
    p_tick_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (scl != $past(scl)));

    // R5: every SCL change while enabled is marked by a tick
    p_edge_has_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (scl != $past(scl))) |-> tick);

    // R7: stored settings hold between full-period ends
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !period_end) |=> ($stable(cfg_sel) && $stable(cfg_last)));

endmodule

bind i2c_bitrate_gen i2c_bitrate_gen_chk #(.SEL_W(SEL_W), .HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tick       (tick_o),
    .scl        (scl_o),
    .running    (running),
    .period_end (period_end),
    .cfg_sel    (cfg_sel),
    .cfg_last   (cfg_last)
);

// File: tb/tb_i2c_bitrate_gen.sv
`timescale 1ns/1ps
module tb_i2c_bitrate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_i = 4'h0;
    logic [7:0] div_i = 8'h0;
    logic       tick_o;
    logic       scl_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    i2c_bitrate_gen dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .div_i  (div_i),
        .tick_o (tick_o),
        .scl_o  (scl_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    // Half period in clock cycles, from the requirements.
    function automatic int hp(input int sel, input int f, input int d);
        return (32 >> sel) * (d + 3 + 2 * f);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a configuration (call at a negedge): bit0 en, bits2:1 sel, bit3 filter.
    task automatic setcfg(input logic en, input logic [1:0] sel, input logic f, input logic [7:0] d);
        mode_i = {f, sel, en};
        div_i  = d;
    endtask

    // Count rising edges until tick is seen at a negedge.
    task automatic wait_tick(output int n, input int lim);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!tick_o && n < lim);
    endtask

    // Enable one configuration and measure both half periods.
    task automatic run_cfg(input int sel, input int f, input int d, input string req);
        int n;
        int e;
        e = hp(sel, f, d);
        setcfg(1'b0, 2'(sel), 1'(f), 8'(d));
        @(negedge clk);
        setcfg(1'b1, 2'(sel), 1'(f), 8'(d));
        wait_tick(n, e + 4);
        chk(n == e, {req, " first half length (R8)"}, n, e);
        chk(scl_o == 1'b1, "R6 first edge rising", int'(scl_o), 1);
        wait_tick(n, e + 4);
        chk(n == e, {req, " low half length (R6)"}, n, e);
        chk(scl_o == 1'b0, "R6 second edge falling", int'(scl_o), 0);
        setcfg(1'b0, 2'(sel), 1'(f), 8'(d));
        @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cycles >= 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        int n;
        int ea;
        int eb;
        bit seen;

        // R1: reset state, even with enable requested
        setcfg(1'b1, 2'd3, 1'b0, 8'd0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!scl_o && !tick_o, "R1 reset outputs low", int'({scl_o, tick_o}), 0);
        setcfg(1'b0, 2'd3, 1'b0, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: disabled for many cycles gives no activity
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick_o || scl_o) seen = 1;
        end
        chk(!seen, "R2 idle while disabled", int'(seen), 0);

        // R3/R4: every select and filter code at several dividers
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 2; f++) begin
                run_cfg(s, f, 0, "R3 R4 sweep");
                run_cfg(s, f, 1, "R3 R4 sweep");
                run_cfg(s, f, 6, "R3 R4 sweep");
            end

        // R4: divider sweep over its low range at the fastest prescaler
        for (int d = 0; d < 64; d++) run_cfg(3, 0, d, "R4 divider sweep");

        // R4: largest divider at both ends of the prescaler
        run_cfg(0, 1, 255, "R4 max slow");
        run_cfg(3, 0, 255, "R4 max fast");

        // R7: changes in mid-period wait for the full-period end
        ea = hp(3, 0, 4);
        eb = hp(2, 1, 1);
        setcfg(1'b1, 2'd3, 1'b0, 8'd4);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        setcfg(1'b1, 2'd2, 1'b1, 8'd1);
        wait_tick(n, ea + 4);
        chk(n + 5 == ea, "R7 first half keeps old settings", n + 5, ea);
        setcfg(1'b1, 2'd1, 1'b0, 8'd9);
        @(posedge clk);
        @(negedge clk);
        setcfg(1'b1, 2'd2, 1'b1, 8'd1);
        wait_tick(n, ea + 4);
        chk(n + 1 == ea, "R7 second half keeps old settings", n + 1, ea);
        wait_tick(n, eb + 4);
        chk(n == eb, "R7 new settings after period end (high)", n, eb);
        wait_tick(n, eb + 4);
        chk(n == eb, "R7 new settings after period end (low)", n, eb);

        // R2: disable while SCL is high, then restart from zero phase
        setcfg(1'b0, 2'd3, 1'b0, 8'd0);
        @(negedge clk);
        setcfg(1'b1, 2'd3, 1'b0, 8'd0);
        wait_tick(n, 20);
        chk(scl_o == 1'b1, "R2 scl high before disable", int'(scl_o), 1);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        setcfg(1'b0, 2'd3, 1'b0, 8'd0);
        @(posedge clk);
        @(negedge clk);
        chk(!scl_o && !tick_o, "R2 disable forces low", int'({scl_o, tick_o}), 0);
        setcfg(1'b1, 2'd3, 1'b0, 8'd0);
        wait_tick(n, 20);
        chk(n == hp(3, 0, 0), "R2 restart from zero phase", n, hp(3, 0, 0));
        chk(scl_o == 1'b1, "R6 restart edge rising", int'(scl_o), 1);
        setcfg(1'b0, 2'd3, 1'b0, 8'd0);
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule